// File: doc/BRIEF.md
# Register-Controlled Reset Hub

This block drives a bank of peripheral reset lines from a small register port. Software selects lines by setting bits in two 32-bit control words. The reset-line number fixes the word and bit position. Most lines behave as one-shot pulses: one write starts a reset, and the block releases the line itself after a fixed number of clocks. A few lines are held instead. They stay in reset until software clears their bit again.

Two read-only status words report the same lines with inverted sense, so a 0 means the line is in reset. Line 0 is the core reset, and while it is active the block raises a request for a whole-system restart. The register port is a single-cycle strobe interface. A write takes effect at the clock edge on which it is presented. Read data is combinational in the strobe cycle.

Top module: `rsthub`

## Requirements
- R1: Control word w sits at offset 0x100 + 4*w and status word w at 0x150 + 4*w (w = 0, 1). Line n is bit (n mod 32) of word (n div 32), so line 63 is bit 31 of the word at 0x104.
- R2: A write with a 1 in a control bit puts that line in reset (`rst_out` bit high) from the cycle after the write edge.
- R3: A self-clearing line stays high for exactly PULSE_CYCLES clock cycles (default 16) after its write, then drops with no further write.
- R4: Writing 1 to a self-clearing line whose pulse is running restarts its count, so it stays high PULSE_CYCLES cycles after the latest write.
- R5: Writing 0 to a self-clearing line has no effect: it neither shortens a running pulse nor starts a new one.
- R6: Lines 12 and 56 do not self-clear. They stay high until a write puts 0 in their control bit, and every write to their word sets their state to the written bit.
- R7: A status bit reads 0 while its line is in reset and 1 while it is released.
- R8: Reading a control word returns the present reset state of its 32 lines (1 = in reset).
- R9: `sys_restart_req` is high exactly while line 0 is in reset, so a write of 1 to bit 0 at 0x100 raises it on the next cycle.
- R10: Reads of any offset other than the four words return 0. Writes to those offsets change no line.
- R11: After the block reset, every line is released except lines 12 and 56, which start in reset. Control words then read 0x00001000 and 0x01000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| reg_sel | input | 1 | Register access strobe for this cycle |
| reg_we | input | 1 | 1 = write, 0 = read (with reg_sel) |
| reg_addr | input | 12 | Byte offset of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle, 0 otherwise |
| rst_out | output | 64 | Reset lines, 1 = in reset |
| sys_restart_req | output | 1 | Whole-system restart request, follows line 0 |

## Verification
The hardest situations to reach are a second event that lands in the middle of a running pulse: a re-trigger, or a write of 0 that must be ignored. The stimulus starts a pulse and waits a known number of cycles before it issues the second write. It then counts the high cycles that remain and compares them with the value worked out from PULSE_CYCLES. A held line can be released by any write to its word, even one aimed at another line, so the vector table writes word 0 for an unrelated line and then checks that line 12 has dropped.

// File: rtl/rsthub_pkg.sv
package rsthub_pkg;
  localparam int ADDR_W    = 12;
  localparam int WORD_W    = 32;
  localparam int CTRL_BASE = 'h100;
  localparam int STAT_BASE = 'h150;
endpackage

// File: rtl/rsthub_regif.sv
module rsthub_regif
  import rsthub_pkg::*;
#(
  parameter int NUM_LINES = 64,
  localparam int NUM_WORDS = (NUM_LINES + WORD_W - 1) / WORD_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_sel,
  input  logic                   reg_we,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [NUM_LINES-1:0]   line_state,
  output logic [NUM_WORDS-1:0]   word_we,
  output logic [WORD_W-1:0]      reg_rdata
);
  logic [NUM_WORDS*WORD_W-1:0] state_pad;
  logic                        hit;

  always_comb begin
    state_pad = '0;
    state_pad[NUM_LINES-1:0] = line_state;
  end

  always_comb begin
    word_we   = '0;
    reg_rdata = '0;
    hit       = 1'b0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (reg_addr == ADDR_W'(CTRL_BASE + 4 * w)) begin
        hit = 1'b1;
        word_we[w] = reg_sel & reg_we;
        if (reg_sel && !reg_we) reg_rdata = state_pad[w*WORD_W +: WORD_W];
      end
      if (reg_addr == ADDR_W'(STAT_BASE + 4 * w)) begin
        hit = 1'b1;
        if (reg_sel && !reg_we) reg_rdata = ~state_pad[w*WORD_W +: WORD_W];
      end
    end
  end

  AST_ONE_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(word_we)) else $error("AST_ONE_WORD_WRITE"); // R1
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !reg_we && !hit) |-> (reg_rdata == '0)) else $error("AST_UNMAPPED_READ_ZERO"); // R10
  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (word_we == '0)) else $error("AST_UNMAPPED_NO_WRITE"); // R10
endmodule

// File: rtl/rsthub_line.sv
module rsthub_line #(
  parameter int PULSE_CYCLES = 16,
  parameter bit HELD         = 1'b0,
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic active
);
  logic             act_q, act_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             upd_en;

  assign upd_en = wr_en | act_q;

  always_comb begin
    act_nxt = act_q;
    cnt_nxt = cnt_q;
    if (HELD) begin
      if (wr_en) act_nxt = wr_bit;
    end else if (wr_en && wr_bit) begin
      act_nxt = 1'b1;
      cnt_nxt = CNT_W'(PULSE_CYCLES - 1);
    end else if (act_q) begin
      if (cnt_q == '0) act_nxt = 1'b0;
      else             cnt_nxt = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= HELD;
      cnt_q <= '0;
    end else if (upd_en) begin
      act_q <= act_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  assign active = act_q;

  AST_SET_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bit) |=> act_q) else $error("AST_SET_ON_WRITE"); // R2
  AST_ZERO_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!HELD && !act_q && !(wr_en && wr_bit)) |=> !act_q) else $error("AST_ZERO_NO_START"); // R5
  AST_HELD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (HELD && !wr_en) |=> $stable(act_q)) else $error("AST_HELD_KEEPS"); // R6
  AST_HELD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (HELD && wr_en && !wr_bit) |=> !act_q) else $error("AST_HELD_RELEASE"); // R6
endmodule

// File: rtl/rsthub.sv
module rsthub
  import rsthub_pkg::*;
#(
  parameter int                   NUM_LINES    = 64,
  parameter int                   PULSE_CYCLES = 16,
  parameter int                   CORE_LINE    = 0,
  parameter logic [NUM_LINES-1:0] HELD_MASK    = 64'h0100_0000_0000_1000,
  localparam int NUM_WORDS = (NUM_LINES + WORD_W - 1) / WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_sel,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic [NUM_LINES-1:0] rst_out,
  output logic                 sys_restart_req
);
  logic [NUM_WORDS-1:0] word_we;
  logic [NUM_LINES-1:0] line_q;

  rsthub_regif #(.NUM_LINES(NUM_LINES)) regif_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .line_state (line_q),
    .word_we    (word_we),
    .reg_rdata  (reg_rdata)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int WI = i / WORD_W;
    localparam int BI = i % WORD_W;
    rsthub_line #(
      .PULSE_CYCLES (PULSE_CYCLES),
      .HELD         (HELD_MASK[i])
    ) line_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (word_we[WI]),
      .wr_bit (reg_wdata[BI]),
      .active (line_q[i])
    );
  end

  assign rst_out         = line_q;
  assign sys_restart_req = line_q[CORE_LINE];

  AST_CORE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_we && reg_addr == ADDR_W'(CTRL_BASE + 4 * (CORE_LINE / WORD_W))
     && reg_wdata[CORE_LINE % WORD_W]) |=> sys_restart_req) else $error("AST_CORE_RESTART"); // R9
  AST_STATUS_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !reg_we && reg_addr == ADDR_W'(STAT_BASE)) |-> (reg_rdata == ~rst_out[WORD_W-1:0]))
    else $error("AST_STATUS_INVERTED"); // R7
endmodule

// File: tb/rsthub_tb_top.sv
module rsthub_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE      = 16;
  localparam int NV         = 22;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_sel, reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [63:0] rst_out;
  logic        sys_restart_req;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rsthub dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rst_out(rst_out), .sys_restart_req(sys_restart_req)
  );

  // {is_write, addr, wdata, expected read data}
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 12'h100, 32'h0, 32'h0000_1000},  // R11 R8
    {1'b0, 12'h104, 32'h0, 32'h0100_0000},  // R11
    {1'b0, 12'h150, 32'h0, 32'hFFFF_EFFF},  // R7
    {1'b0, 12'h154, 32'h0, 32'hFEFF_FFFF},  // R7
    {1'b1, 12'h100, 32'h0000_0020, 32'h0},  // start line 5, release line 12
    {1'b0, 12'h100, 32'h0, 32'h0000_0020},  // R2 R6
    {1'b0, 12'h150, 32'h0, 32'hFFFF_FFDF},  // R7
    {1'b1, 12'h148, 32'hFFFF_FFFF, 32'h0},  // unmapped write
    {1'b0, 12'h148, 32'h0, 32'h0},          // R10
    {1'b0, 12'h104, 32'h0, 32'h0100_0000},  // R10
    {1'b1, 12'h104, 32'h0000_0001, 32'h0},  // start line 32, release 56
    {1'b0, 12'h104, 32'h0, 32'h0000_0001},  // R1 R6
    {1'b0, 12'h000, 32'h0, 32'h0},
    {1'b0, 12'h000, 32'h0, 32'h0},
    {1'b0, 12'h000, 32'h0, 32'h0},
    {1'b0, 12'h000, 32'h0, 32'h0},
    {1'b0, 12'h000, 32'h0, 32'h0},
    {1'b0, 12'h000, 32'h0, 32'h0},
    {1'b0, 12'h000, 32'h0, 32'h0},
    {1'b0, 12'h000, 32'h0, 32'h0},
    {1'b0, 12'h100, 32'h0, 32'h0000_0020},  // R3 last high cycle
    {1'b0, 12'h100, 32'h0, 32'h0}           // R3 released
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic count_high(input int b, output int n);
    n = 0;
    while (rst_out[b] && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; reg_sel = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    check("R11 reset lines", rst_out, 64'h0100_0000_0000_1000);
    check("R11 restart idle", {63'b0, sys_restart_req}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      reg_sel  = 1'b1;
      reg_we   = VEC[k][76];
      reg_addr = VEC[k][75:64];
      reg_wdata = VEC[k][63:32];
      #1;
      if (!VEC[k][76]) check($sformatf("R1/R3/R7/R8/R10 vector %0d", k), {32'b0, reg_rdata}, {32'b0, VEC[k][31:0]});
      @(negedge clk);
    end
    reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    repeat (30) @(negedge clk);
    check("R3 all pulses ended", rst_out, 64'h0);

    // R3 full pulse length
    do_wr(12'h100, 32'h0000_0002);
    count_high(1, n);
    check("R3 pulse length", 64'(n), 64'(PULSE));

    // R4 retrigger after 10 cycles
    do_wr(12'h100, 32'h0000_0008);
    repeat (10) @(negedge clk);
    do_wr(12'h100, 32'h0000_0008);
    count_high(3, n);
    check("R4 retrigger length", 64'(n), 64'(PULSE));

    // R5 write 0 mid-pulse: 1 + 3 cycles already spent
    do_wr(12'h100, 32'h0000_0080);
    repeat (3) @(negedge clk);
    do_wr(12'h100, 32'h0000_0000);
    check("R5 idle line not started", {63'b0, rst_out[8]}, 64'h0);
    count_high(7, n);
    check("R5 remaining length", 64'(n), 64'(PULSE - 4));

    // R9 core line drives restart request
    do_wr(12'h100, 32'h0000_0001);
    check("R9 restart raised", {63'b0, sys_restart_req}, 64'h1);
    repeat (PULSE) @(negedge clk);
    check("R9 restart dropped", {63'b0, sys_restart_req}, 64'h0);

    // R6 held line stays until cleared
    do_wr(12'h104, 32'h0100_0000);
    repeat (40) @(negedge clk);
    check("R6 line 56 held", {63'b0, rst_out[56]}, 64'h1);
    do_wr(12'h104, 32'h0000_0000);
    check("R6 line 56 released", {63'b0, rst_out[56]}, 64'h0);

    // R1 top bit mapping
    do_wr(12'h104, 32'h8000_0000);
    check("R1 line 63 mapping", rst_out, 64'h8000_0000_0000_0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule